// File: doc/BRIEF.md
# Debounced 4x3 Keypad Scanner

This block scans a twelve-key mechanical keypad laid out as four rows by three columns. It drives the rows with a single rotating low level and reads the three column lines, which idle high through pull-ups. When a key is pressed, its column is pulled low while its row is the one being driven. Two free-running dividers make a fast row-advance tick and a slower sampling tick from the system clock. The column lines pass through a two-stage synchronizer before they reach any logic.

A press is accepted only after the sampling tick has seen the same active column pattern on two samples in a row. While a press is being tracked, the row rotation stops, so the pressed key stays visible until it is released. Each accepted press gives a one-cycle `key_valid` pulse with a 4-bit code and a flag that separates digit keys from function keys. A key that is held gives no more pulses. The keypad has to read idle on two consecutive samples before another press can be taken. Downstream logic, such as an entry buffer for a combination lock, can take the code on the pulse without any further filtering.

Top module: `keypad_scanner`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `row_n` reads 1110, and `key_valid`, `key_code` and `key_func` are all zero.
- R2: When no key is active, `row_n` has exactly one bit low and steps through 1110, 1101, 1011, 0111 and back to 1110. It advances once per scan tick.
- R3: Row index r is the position of the low bit of `row_n`, counted from bit 0. Column c is the `col_n` bit that reads low, so a press in the third column reads 011. For r = 0, 1 or 2, a key reports digit 3r+c+1 with `key_func`=0. For row 3, column 1 reports digit 0 with `key_func`=0. Column 0 (the star key) reports 0100 with `key_func`=1, and column 2 (the hash key) reports 0001 with `key_func`=1.
- R4: While a column reads active, or while a press is being tracked or released, `row_n` holds its value. A held key therefore keeps its own row driven.
- R5: A key is accepted only when two consecutive sampling ticks both see the same active column pattern. Activity shorter than one sampling period gives no pulse.
- R6: `key_valid` is high for exactly one clock cycle per accepted press. `key_code` and `key_func` change only with that pulse and hold their values until the next one.
- R7: A key held for any length of time gives one pulse. A new pulse needs the columns to read idle (111) on two consecutive sampling ticks first.
- R8: A release gap shorter than one sampling period, followed by a renewed press, gives no second pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| col_n | input | 3 | Column sense lines, active low |
| row_n | output | 4 | Row drive lines, one low at a time |
| key_valid | output | 1 | One-cycle pulse for an accepted press |
| key_code | output | 4 | Code of the last accepted key |
| key_func | output | 1 | 1 when the last accepted key is a function key |

## Verification
The bench models the keypad as a switch that pulls its column low only while its own row is driven. It sweeps all twelve keys, so a design with a swapped row or column mapping, or with the function codes mixed up, reports the wrong code or flag. It applies glitches shorter than one sampling period and release gaps of the same length. A design that accepts on a single sample, or that lets a brief release re-arm it, gives extra pulses. It also holds keys for long stretches and checks the row lines during the hold. A design that keeps scanning, or that repeats held keys, either drops the press or pulses more than once.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

  localparam int ROWS   = 4;
  localparam int COLS   = 3;
  localparam int CODE_W = 4;
  localparam int RIDX_W = $clog2(ROWS);

  typedef enum logic [1:0] {
    DB_IDLE = 2'd0,
    DB_PEND = 2'd1,
    DB_HELD = 2'd2,
    DB_REL  = 2'd3
  } db_state_t;

  typedef struct packed {
    logic              fn;
    logic [CODE_W-1:0] code;
  } key_t;

  localparam logic [CODE_W-1:0] CODE_STAR = 4'b0100;
  localparam logic [CODE_W-1:0] CODE_HASH = 4'b0001;

  // Map the driven row and the synchronized column pattern to a key.
  function automatic key_t key_decode(input logic [RIDX_W-1:0] r,
                                      input logic [COLS-1:0]   cols);
    key_t              k;
    logic [CODE_W-1:0] c;
    c = 4'd2;
    if (!cols[0])      c = 4'd0;
    else if (!cols[1]) c = 4'd1;
    k.fn   = 1'b0;
    k.code = '0;
    if (r != RIDX_W'(ROWS - 1)) begin
      k.code = CODE_W'(r) * 4'd3 + c + 4'd1;
    end else begin
      case (c)
        4'd0:    begin k.fn = 1'b1; k.code = CODE_STAR; end
        4'd1:    begin k.fn = 1'b0; k.code = 4'd0;      end
        default: begin k.fn = 1'b1; k.code = CODE_HASH; end
      endcase
    end
    return k;
  endfunction

endpackage

// File: rtl/keypad_tick_gen.sv
module keypad_tick_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_q, tick_d;

  always_comb begin
    cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    tick_d = (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick = tick_q;

endmodule

// File: rtl/keypad_col_sync.sv
module keypad_col_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] s1_q, s2_q;

  // Resets to the idle (all high) level of the active-low lines.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_async;
      s2_q <= s1_q;
    end
  end

  assign d_sync = s2_q;

endmodule

// File: rtl/keypad_row_scan.sv
module keypad_row_scan
  import keypad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_tick,
  input  logic              freeze,
  output logic [RIDX_W-1:0] row_idx,
  output logic [ROWS-1:0]   row_n
);
  logic [RIDX_W-1:0] idx_q, idx_d;

  always_comb begin
    idx_d = idx_q;
    if (scan_tick && !freeze) begin
      idx_d = (idx_q == RIDX_W'(ROWS - 1)) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // One-hot-low drive built from the index, one bit per row.
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign row_n[g] = (idx_q != RIDX_W'(g));
  end

  assign row_idx = idx_q;

  a_r2_one_low: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~row_n) == 1);

  a_r2_rotate_order: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_n) |-> row_n == {$past(row_n[ROWS-2:0]), $past(row_n[ROWS-1])});

  a_r4_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(row_n));

endmodule

// File: rtl/keypad_debounce.sv
module keypad_debounce
  import keypad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_tick,
  input  logic [COLS-1:0]   cols,
  input  logic [RIDX_W-1:0] row_idx,
  output logic              busy,
  output logic              key_valid,
  output logic [CODE_W-1:0] key_code,
  output logic              key_func
);
  db_state_t         st_q, st_d;
  logic [COLS-1:0]   cap_q, cap_d;
  logic              vld_q, vld_d;
  key_t              key_q, key_d;
  logic              active;

  assign active = (cols != '1);

  always_comb begin
    st_d  = st_q;
    cap_d = cap_q;
    vld_d = 1'b0;
    key_d = key_q;
    if (samp_tick) begin
      case (st_q)
        DB_IDLE: begin
          if (active) begin
            st_d  = DB_PEND;
            cap_d = cols;
          end
        end
        DB_PEND: begin
          if (active && cols == cap_q) begin
            st_d  = DB_HELD;
            vld_d = 1'b1;
            key_d = key_decode(row_idx, cols);
          end else begin
            st_d = DB_IDLE;
          end
        end
        DB_HELD: begin
          if (!active) st_d = DB_REL;
        end
        default: begin
          st_d = active ? DB_HELD : DB_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DB_IDLE;
      cap_q <= '1;
      vld_q <= 1'b0;
      key_q <= '0;
    end else begin
      st_q  <= st_d;
      cap_q <= cap_d;
      vld_q <= vld_d;
      key_q <= key_d;
    end
  end

  assign busy      = (st_q != DB_IDLE);
  assign key_valid = vld_q;
  assign key_code  = key_q.code;
  assign key_func  = key_q.fn;

  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid);

  a_r5_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> $past(st_q) == DB_PEND && $past(samp_tick));

  a_r6_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |-> $stable(key_code) && $stable(key_func));

  a_r7_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st_q) == DB_HELD |-> !key_valid);

endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import keypad_pkg::*;
#(
  parameter int SCAN_DIV   = 2000,
  parameter int SAMPLE_DIV = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COLS-1:0]   col_n,
  output logic [ROWS-1:0]   row_n,
  output logic              key_valid,
  output logic [CODE_W-1:0] key_code,
  output logic              key_func
);
  logic              scan_tick, samp_tick;
  logic [COLS-1:0]   cols;
  logic [RIDX_W-1:0] row_idx;
  logic              busy, freeze;

  keypad_tick_gen #(.DIV(SCAN_DIV)) u_scan_tick (
    .clk(clk), .rst_n(rst_n), .tick(scan_tick));

  keypad_tick_gen #(.DIV(SAMPLE_DIV)) u_samp_tick (
    .clk(clk), .rst_n(rst_n), .tick(samp_tick));

  keypad_col_sync #(.W(COLS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(col_n), .d_sync(cols));

  assign freeze = busy || (cols != '1);

  keypad_row_scan u_rows (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .freeze(freeze),
    .row_idx(row_idx), .row_n(row_n));

  keypad_debounce u_db (
    .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .cols(cols),
    .row_idx(row_idx), .busy(busy), .key_valid(key_valid),
    .key_code(key_code), .key_func(key_func));

endmodule

// File: tb/keypad_scanner_test.sv
module keypad_scanner_test;
  localparam int SCAN = 4;
  localparam int SAMP = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] col_n;
  logic [3:0] row_n;
  logic       key_valid;
  logic [3:0] key_code;
  logic       key_func;

  logic pressed = 1'b0;
  int   prow = 0;
  int   pcol = 0;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  int width_err = 0;
  int rot_err = 0;
  int row_steps = 0;
  logic [3:0] last_code = '0;
  logic       last_func = 1'b0;
  logic       prev_v = 1'b0;
  logic [3:0] prev_row = 4'b1110;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  // Keypad model: the switch connects its column to its row only while that row is low.
  assign col_n = (pressed && row_n[prow] == 1'b0) ? (3'b111 & ~(3'b001 << pcol)) : 3'b111;

  keypad_scanner #(.SCAN_DIV(SCAN), .SAMPLE_DIV(SAMP)) uut (
    .clk(clk), .rst_n(rst_n), .col_n(col_n), .row_n(row_n),
    .key_valid(key_valid), .key_code(key_code), .key_func(key_func));

  always @(negedge clk) begin
    if (rst_n) begin
      if (key_valid) begin
        pulses++;
        last_code = key_code;
        last_func = key_func;
        if (prev_v) width_err++;
      end
      prev_v = key_valid;
      if (row_n != prev_row) begin
        row_steps++;
        if (row_n != {prev_row[2:0], prev_row[3]}) rot_err++;
      end
      prev_row = row_n;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_key(input int k);
    int r, c;
    r = k / 3;
    c = k % 3;
    if (r < 3) return {1'b0, 4'(3 * r + c + 1)};
    if (c == 0) return 5'b1_0100;
    if (c == 1) return 5'b0_0000;
    return 5'b1_0001;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic full_press(input int k, input int hold);
    int n0;
    logic [4:0] e;
    n0 = pulses;
    e = exp_key(k);
    prow = k / 3;
    pcol = k % 3;
    pressed = 1'b1;
    wait_clk(hold);
    check(row_n == ~(4'b0001 << prow), "R4 row held during press", row_n, ~(4'b0001 << prow) & 4'hf);
    check(key_code == e[3:0], "R6 code held while key down", key_code, e[3:0]);
    pressed = 1'b0;
    wait_clk(40);
    check(pulses - n0 == 1, "R7 one pulse per press", pulses - n0, 1);
    check({last_func, last_code} == e, "R3 key map", {last_func, last_code}, e);
  endtask

  initial begin
    int seed;
    int n0;
    seed = 32'h1234;
    void'($urandom(seed));
    rst_n = 1'b0;
    wait_clk(3);
    check(row_n == 4'b1110, "R1 reset row", row_n, 4'b1110);
    check(key_valid == 1'b0, "R1 reset valid", key_valid, 0);
    check({key_func, key_code} == 5'd0, "R1 reset code", {key_func, key_code}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(row_n == 4'b1110 && !key_valid, "R1 first cycle after reset", row_n, 4'b1110);

    wait_clk(40);
    check(row_steps >= 8 && rot_err == 0, "R2 walking-zero order", rot_err, 0);

    for (int k = 0; k < 12; k++) full_press(k, 80);

    for (int i = 0; i < 10; i++) begin
      full_press(int'($urandom_range(11, 0)), int'($urandom_range(150, 70)));
    end

    // R7: long hold, then a fresh press of the same key after a clean release.
    full_press(5, 400);
    full_press(5, 80);

    // R5: short glitches shorter than one sampling period.
    for (int i = 0; i < 8; i++) begin
      n0 = pulses;
      prow = int'($urandom_range(3, 0));
      pcol = int'($urandom_range(2, 0));
      pressed = 1'b1;
      wait_clk(int'($urandom_range(SAMP - 1, 1)));
      pressed = 1'b0;
      wait_clk(40);
      check(pulses == n0, "R5 glitch ignored", pulses - n0, 0);
    end

    // R8: brief release gap inside a long press.
    for (int i = 0; i < 6; i++) begin
      n0 = pulses;
      prow = int'($urandom_range(3, 0));
      pcol = int'($urandom_range(2, 0));
      pressed = 1'b1;
      wait_clk(80);
      pressed = 1'b0;
      wait_clk(int'($urandom_range(SAMP - 1, 1)));
      pressed = 1'b1;
      wait_clk(60);
      pressed = 1'b0;
      wait_clk(40);
      check(pulses - n0 == 1, "R8 short gap no retrigger", pulses - n0, 1);
    end

    check(width_err == 0, "R6 pulse one cycle wide", width_err, 0);
    check(rot_err == 0, "R2 rotation order overall", rot_err, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule